// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block sits beside a bus master and states how many clock cycles each memory access is charged. A 16-bit timing word, written through a simple write port, selects the first-access and sequential wait counts for three external ROM windows and for a byte-wide backup RAM region. From these 16-bit settings the block derives the 32-bit timings itself; they are not stored separately. All other regions have fixed timings: one external work-RAM region and a set of zero-wait regions.

For every access the master presents an address, a width (16 or 32 bits), a sequential flag, a load/store flag and a word count for multi-word transfers. The region is taken from address bits 27:24. The block computes the cycle total, registers it, and holds `ready` low for exactly that many cycles. It also reports the wait that an instruction prefetcher would see in the addressed region, so a fetch unit can use the same table.

Top module: `bus_wait_gen`

## Requirements
- R1: The first-access code of each field maps 0→4, 1→3, 2→2, 3→8 wait cycles, giving the 16-bit non-sequential wait. The fields are: ROM window 0 in cfg bits 3:2, window 1 in bits 6:5, window 2 in bits 9:8, and the backup RAM in bits 1:0.
- R2: The sequential-select bits are cfg bit 4 (window 0), bit 7 (window 1) and bit 10 (window 2). Each gives a 16-bit sequential wait of 1 when set. When clear, the wait is 2 for window 0, 4 for window 1 and 8 for window 2.
- R3: For a ROM window, the 32-bit non-sequential wait is the 16-bit non-sequential wait plus the 16-bit sequential wait plus 1, and the 32-bit sequential wait is twice the 16-bit sequential wait plus 1. For the backup RAM, both 16-bit waits equal its coded wait, and both 32-bit waits are twice that wait plus 1.
- R4: The region is address bits 27:24. Regions 8/9 use window 0, 10/11 use window 1, 12/13 use window 2, and 14 uses the backup RAM. Region 2 has fixed waits: 2 for 16-bit accesses and 5 for 32-bit accesses, sequential or not. Every other region has zero wait.
- R5: After reset the timing word is 0. This gives the following 16-bit waits and 32-bit non-sequential waits:
  - region 2: 16-bit 2, 32-bit 5
  - regions 8 to 14: 16-bit 4
  - regions 8 to 14, 32-bit, in order: 7, 7, 9, 9, 13, 13, 9
- R6: A single access (burst count 0 or 1) costs a base plus the region wait. The base is 2 for a load (`req_write`=0) and 1 for a store. The wait is chosen by `req_wide` (1 = 32-bit) and `req_seq` (1 = sequential).
- R7: A burst count N ≥ 2 costs (1 + 32-bit non-sequential wait) + (N−1)·(1 + 32-bit sequential wait). This holds regardless of width, sequential and load/store flags.
- R8: A request is accepted when `req_valid` and `ready` are both high at a clock edge. `ready` is then low for exactly `acc_cost` cycles. Requests presented while `ready` is low are ignored.
- R9: A timing-word write and a request accepted at the same edge use the old timing word. Requests accepted at later edges use the new one.
- R10: `acc_pf_wait` is 0 for regions 8–13 when cfg bit 14 is set. Otherwise it equals the addressed region's sequential wait for the access width.
- R11: `acc_cost` and `acc_pf_wait` are 0 after reset. They change only at an accepting edge and are held until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing-word write strobe |
| cfg_wdata | input | 16 | Timing word to write |
| req_valid | input | 1 | Access request |
| req_addr | input | ADDR_W | Access address; bits 27:24 pick the region |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| req_seq | input | 1 | 1 = sequential access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_burst | input | BURST_W | Word count of a burst; 0 or 1 = single access |
| ready | output | 1 | High when a new request can be accepted |
| acc_cost | output | COST_W | Cycle total of the last accepted access |
| acc_pf_wait | output | 5 | Prefetch wait of the last accepted access's region |

## Verification
The results `acc_cost` and `acc_pf_wait` become valid at the first sample after the accepting edge. From that same edge, `ready` stays low for exactly `acc_cost` samples. A timing-word write affects only requests accepted at a later edge.

The bench holds a behavioural model that advances on each rising edge from the same inputs. It compares all three outputs at every falling edge, so every cycle of every stall window is checked. Directed checks sample `acc_cost` one falling edge after the request. They count the low samples of `ready` until it rises again.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
   localparam int unsigned WAIT_W           = 5;
   localparam int unsigned REGION_W         = 4;
   localparam int unsigned NUM_REGIONS      = 1 << REGION_W;
   localparam int unsigned NUM_WIN          = 3;
   localparam int unsigned XRAM_REGION      = 2;
   localparam int unsigned WIN_BASE_REGION  = 8;
   localparam int unsigned SRAM_REGION      = 14;
   localparam int unsigned CFG_W            = 16;
   localparam int unsigned FIELD_BITS       = 11;
   localparam int unsigned SRAM_CODE_LSB    = 0;
   localparam int unsigned WIN_FIELD_LSB    = 2;
   localparam int unsigned WIN_FIELD_STRIDE = 3;
   localparam int unsigned PF_EN_BIT        = 14;
   localparam int unsigned XRAM_WAIT16      = 2;
   localparam int unsigned XRAM_WAIT32      = 5;

   typedef logic [WAIT_W-1:0] wait_t;

   typedef struct packed {
      wait_t n16;
      wait_t s16;
      wait_t n32;
      wait_t s32;
      wait_t pf16;
      wait_t pf32;
   } timing_t;

   // R1: first-access code to wait count
   function automatic wait_t first_wait(input logic [1:0] code);
      case (code)
         2'd0:    return wait_t'(4);
         2'd1:    return wait_t'(3);
         2'd2:    return wait_t'(2);
         default: return wait_t'(8);
      endcase
   endfunction
endpackage

// File: rtl/wsg_win_dec.sv
module wsg_win_dec
   import wsg_pkg::*;
#(
   parameter int unsigned SLOW_SEQ = 2
) (
   input  logic [1:0] code,
   input  logic       seq_fast,
   input  logic       pf_en,
   output timing_t    t
);
   wait_t n16, s16, n32, s32;

   // R1, R2: 16-bit waits from the window field
   assign n16 = first_wait(code);
   assign s16 = seq_fast ? wait_t'(1) : wait_t'(SLOW_SEQ);
   // R3: derived 32-bit timings
   assign n32 = n16 + s16 + wait_t'(1);
   assign s32 = (s16 << 1) + wait_t'(1);

   // R10: prefetch hides the sequential wait of ROM windows
   always_comb begin
      t.n16  = n16;
      t.s16  = s16;
      t.n32  = n32;
      t.s32  = s32;
      t.pf16 = pf_en ? '0 : s16;
      t.pf32 = pf_en ? '0 : s32;
   end
endmodule

// File: rtl/wsg_sram_dec.sv
module wsg_sram_dec
   import wsg_pkg::*;
(
   input  logic [1:0] code,
   output timing_t    t
);
   wait_t w16, w32;

   assign w16 = first_wait(code);            // R1
   assign w32 = (w16 << 1) + wait_t'(1);     // R3

   always_comb begin
      t.n16  = w16;
      t.s16  = w16;
      t.n32  = w32;
      t.s32  = w32;
      t.pf16 = w16;
      t.pf32 = w32;
   end
endmodule

// File: rtl/wsg_region_map.sv
module wsg_region_map
   import wsg_pkg::*;
(
   input  timing_t             win_t [NUM_WIN],
   input  timing_t             sram_t,
   input  logic [REGION_W-1:0] region,
   output timing_t             sel
);
   timing_t tbl [NUM_REGIONS];

   // R4: one table entry per region, built by kind
   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
      if (r == XRAM_REGION) begin : g_xram
         assign tbl[r] = '{n16:  wait_t'(XRAM_WAIT16), s16:  wait_t'(XRAM_WAIT16),
                           n32:  wait_t'(XRAM_WAIT32), s32:  wait_t'(XRAM_WAIT32),
                           pf16: wait_t'(XRAM_WAIT16), pf32: wait_t'(XRAM_WAIT32)};
      end else if (r >= WIN_BASE_REGION && r < WIN_BASE_REGION + 2 * NUM_WIN) begin : g_win
         assign tbl[r] = win_t[(r - WIN_BASE_REGION) / 2];
      end else if (r == SRAM_REGION) begin : g_sram
         assign tbl[r] = sram_t;
      end else begin : g_zero
         assign tbl[r] = '0;
      end
   end

   assign sel = tbl[region];
endmodule

// File: rtl/wsg_cost_calc.sv
module wsg_cost_calc
   import wsg_pkg::*;
#(
   parameter int unsigned BURST_W = 8,
   parameter int unsigned COST_W  = BURST_W + 6
) (
   input  timing_t             t,
   input  logic                wide,
   input  logic                seq,
   input  logic                write,
   input  logic [BURST_W-1:0]  burst,
   output logic [COST_W-1:0]   total,
   output wait_t               pf
);
   wait_t             w_single;
   logic [COST_W-1:0] single_total;
   logic [COST_W-1:0] burst_total;
   logic [COST_W-1:0] n_rest;
   logic [COST_W-1:0] s_step;
   logic              is_burst;

   always_comb begin
      case ({wide, seq})
         2'b00:   w_single = t.n16;
         2'b01:   w_single = t.s16;
         2'b10:   w_single = t.n32;
         default: w_single = t.s32;
      endcase
      // R6: base 2 for loads, 1 for stores
      single_total = COST_W'(w_single) + (write ? COST_W'(1) : COST_W'(2));
      // R7: first word non-sequential, the rest sequential
      is_burst     = burst > BURST_W'(1);
      n_rest       = COST_W'(burst) - COST_W'(1);
      s_step       = COST_W'(t.s32) + COST_W'(1);
      burst_total  = COST_W'(t.n32) + COST_W'(1) + n_rest * s_step;
      total        = is_burst ? burst_total : single_total;
      pf           = wide ? t.pf32 : t.pf16;   // R10
   end
endmodule

// File: rtl/wsg_stall_ctr.sv
module wsg_stall_ctr
   import wsg_pkg::*;
#(
   parameter int unsigned COST_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [COST_W-1:0] total,
   input  wait_t             pf_in,
   output logic              ready,
   output logic [COST_W-1:0] cost_q,
   output wait_t             pf_q
);
   logic [COST_W-1:0] cnt;
   logic              accept;

   assign ready  = (cnt == '0);
   assign accept = req_valid && ready;

   // R8, R11: load on acceptance, count down while stalled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         cost_q <= '0;
         pf_q   <= '0;
      end else if (accept) begin
         cnt    <= total;
         cost_q <= total;
         pf_q   <= pf_in;
      end else if (!ready) begin
         cnt    <= cnt - COST_W'(1);
      end
   end
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
   import wsg_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned REGION_LSB = 24,
   parameter int unsigned BURST_W    = 8,
   parameter int unsigned COST_W     = BURST_W + 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CFG_W-1:0]   cfg_wdata,
   input  logic               req_valid,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic               req_wide,
   input  logic               req_seq,
   input  logic               req_write,
   input  logic [BURST_W-1:0] req_burst,
   output logic               ready,
   output logic [COST_W-1:0]  acc_cost,
   output logic [WAIT_W-1:0]  acc_pf_wait
);
   initial begin : p_param_chk
      assert (ADDR_W >= REGION_LSB + REGION_W)
         else $error("bus_wait_gen: region field exceeds address width");
      assert (BURST_W >= 1)
         else $error("bus_wait_gen: BURST_W must be at least 1");
      assert (COST_W >= BURST_W + 5)
         else $error("bus_wait_gen: COST_W too narrow for the longest burst");
   end

   // Timing word: wait fields and prefetch enable; other bits are reserved
   logic [FIELD_BITS-1:0] field_q;
   logic                  pf_en_q;
   logic                  cfg_unused;
   logic                  addr_unused;

   assign cfg_unused  = ^cfg_wdata;
   assign addr_unused = ^req_addr;

   // R5, R9: reset to zero; a write is seen from the next edge on
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_q <= '0;
         pf_en_q <= 1'b0;
      end else if (cfg_we) begin
         field_q <= cfg_wdata[FIELD_BITS-1:0];
         pf_en_q <= cfg_wdata[PF_EN_BIT];
      end
   end

   timing_t win_t [NUM_WIN];
   timing_t sram_t;
   timing_t sel_t;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_window
      localparam int unsigned LSB = WIN_FIELD_LSB + w * WIN_FIELD_STRIDE;
      wsg_win_dec #(
         .SLOW_SEQ (2 << w)
      ) u_dec (
         .code     (field_q[LSB+1:LSB]),
         .seq_fast (field_q[LSB+2]),
         .pf_en    (pf_en_q),
         .t        (win_t[w])
      );
   end

   wsg_sram_dec u_sram_dec (
      .code (field_q[SRAM_CODE_LSB+1:SRAM_CODE_LSB]),
      .t    (sram_t)
   );

   logic [REGION_W-1:0] region_idx;
   assign region_idx = req_addr[REGION_LSB +: REGION_W];

   wsg_region_map u_map (
      .win_t  (win_t),
      .sram_t (sram_t),
      .region (region_idx),
      .sel    (sel_t)
   );

   logic [COST_W-1:0] total;
   wait_t             pf_now;

   wsg_cost_calc #(
      .BURST_W (BURST_W),
      .COST_W  (COST_W)
   ) u_cost (
      .t     (sel_t),
      .wide  (req_wide),
      .seq   (req_seq),
      .write (req_write),
      .burst (req_burst),
      .total (total),
      .pf    (pf_now)
   );

   wsg_stall_ctr #(
      .COST_W (COST_W)
   ) u_stall (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .total     (total),
      .pf_in     (pf_now),
      .ready     (ready),
      .cost_q    (acc_cost),
      .pf_q      (acc_pf_wait)
   );
endmodule

// File: rtl/bus_wait_gen_chk.sv
module bus_wait_gen_chk
   import wsg_pkg::*;
#(
   parameter int unsigned BURST_W = 8,
   parameter int unsigned COST_W  = BURST_W + 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [REGION_W-1:0] region,
   input logic                req_wide,
   input logic                req_write,
   input logic [BURST_W-1:0]  req_burst,
   input logic                ready,
   input logic [COST_W-1:0]   acc_cost,
   input logic [WAIT_W-1:0]   acc_pf_wait,
   input logic                pf_en_q
);
   logic              accept;
   logic              single;
   logic              zero_region;
   logic              rom_region;
   logic [COST_W-1:0] low_cnt;

   assign accept      = req_valid && ready;
   assign single      = req_burst < BURST_W'(2);
   assign rom_region  = (region >= REGION_W'(WIN_BASE_REGION)) && (region < REGION_W'(SRAM_REGION));
   assign zero_region = (region != REGION_W'(XRAM_REGION)) && !rom_region && (region != REGION_W'(SRAM_REGION));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      low_cnt <= '0;
      else if (accept) low_cnt <= '0;
      else if (!ready) low_cnt <= low_cnt + COST_W'(1);
   end

   AST_STALL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !ready);  // R8

   AST_STALL_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (low_cnt == acc_cost));  // R8

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(accept) |-> ($stable(acc_cost) && $stable(acc_pf_wait)));  // R11

   AST_ZERO_REGION_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && single && req_write && zero_region) |=> (acc_cost == COST_W'(1)));  // R4

   AST_XRAM_LOAD16: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && single && !req_write && !req_wide && region == REGION_W'(XRAM_REGION))
      |=> (acc_cost == COST_W'(4)));  // R4

   AST_PF_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pf_en_q && rom_region) |=> (acc_pf_wait == '0));  // R10
endmodule

bind bus_wait_gen bus_wait_gen_chk #(
   .BURST_W (BURST_W),
   .COST_W  (COST_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .region      (region_idx),
   .req_wide    (req_wide),
   .req_write   (req_write),
   .req_burst   (req_burst),
   .ready       (ready),
   .acc_cost    (acc_cost),
   .acc_pf_wait (acc_pf_wait),
   .pf_en_q     (pf_en_q)
);

// File: tb/bus_wait_gen_bench.sv
module bus_wait_gen_bench;
   localparam int unsigned ADDR_W  = 32;
   localparam int unsigned BURST_W = 8;
   localparam int unsigned COST_W  = BURST_W + 6;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_we = 1'b0;
   logic [15:0]        cfg_wdata = '0;
   logic               req_valid = 1'b0;
   logic [ADDR_W-1:0]  req_addr = '0;
   logic               req_wide = 1'b0;
   logic               req_seq = 1'b0;
   logic               req_write = 1'b0;
   logic [BURST_W-1:0] req_burst = '0;
   logic               ready;
   logic [COST_W-1:0]  acc_cost;
   logic [4:0]         acc_pf_wait;

   always #10 clk = ~clk;

   bus_wait_gen #(
      .ADDR_W  (ADDR_W),
      .BURST_W (BURST_W),
      .COST_W  (COST_W)
   ) u_bus_wait_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_wdata   (cfg_wdata),
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .req_wide    (req_wide),
      .req_seq     (req_seq),
      .req_write   (req_write),
      .req_burst   (req_burst),
      .ready       (ready),
      .acc_cost    (acc_cost),
      .acc_pf_wait (acc_pf_wait)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;
   string cur_req  = "R11";

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   function automatic int code_wait(input int code);
      case (code)
         0: return 4;
         1: return 3;
         2: return 2;
         default: return 8;
      endcase
   endfunction

   function automatic void ref_timing(input int cfg, input int region,
                                      output int n16, output int s16, output int n32,
                                      output int s32, output int pf16, output int pf32);
      int win;
      n16 = 0; s16 = 0; n32 = 0; s32 = 0; pf16 = 0; pf32 = 0;
      if (region == 2) begin
         n16 = 2; s16 = 2; n32 = 5; s32 = 5; pf16 = 2; pf32 = 5;
      end else if (region >= 8 && region <= 13) begin
         win = (region - 8) / 2;
         n16 = code_wait((cfg >> (2 + 3 * win)) & 3);
         if (((cfg >> (4 + 3 * win)) & 1) == 1) s16 = 1;
         else if (win == 0) s16 = 2;
         else if (win == 1) s16 = 4;
         else s16 = 8;
         n32 = n16 + s16 + 1;
         s32 = 2 * s16 + 1;
         if (((cfg >> 14) & 1) == 1) begin pf16 = 0; pf32 = 0; end
         else begin pf16 = s16; pf32 = s32; end
      end else if (region == 14) begin
         n16 = code_wait(cfg & 3);
         s16 = n16; n32 = 2 * n16 + 1; s32 = n32; pf16 = s16; pf32 = s32;
      end
   endfunction

   int m_cfg = 0, m_cnt = 0, m_cost = 0, m_pf = 0;

   always @(posedge clk) begin
      int n16, s16, n32, s32, pf16, pf32, w, region, tot;
      if (!rst_n) begin
         m_cfg = 0; m_cnt = 0; m_cost = 0; m_pf = 0;
      end else begin
         if (req_valid && m_cnt == 0) begin
            region = int'(req_addr[27:24]);
            ref_timing(m_cfg, region, n16, s16, n32, s32, pf16, pf32);
            if (req_burst >= 2)
               tot = (1 + n32) + (int'(req_burst) - 1) * (1 + s32);
            else begin
               if (req_wide) w = req_seq ? s32 : n32;
               else          w = req_seq ? s16 : n16;
               tot = (req_write ? 1 : 2) + w;
            end
            m_cnt = tot; m_cost = tot; m_pf = req_wide ? pf32 : pf16;
         end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
         end
         if (cfg_we) m_cfg = int'(cfg_wdata);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({cur_req, " ready"}, int'(ready), (m_cnt == 0) ? 1 : 0);
         check({cur_req, " acc_cost"}, int'(acc_cost), m_cost);
         check({cur_req, " acc_pf_wait"}, int'(acc_pf_wait), m_pf);
      end
   end

   // ---------------- watchdog ----------------
   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   function automatic logic [ADDR_W-1:0] addr_of(input int region);
      return {4'h0, 4'(region), 24'h000120};
   endfunction

   task automatic write_cfg(input int value);
      cfg_we    = 1'b1;
      cfg_wdata = 16'(value);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic issue(input int region, input bit wide, input bit seq, input bit wr,
                        input int burst, input int exp_cost, input int exp_pf, input string tag);
      while (!ready) @(negedge clk);
      cur_req   = tag;
      req_addr  = addr_of(region);
      req_wide  = wide;
      req_seq   = seq;
      req_write = wr;
      req_burst = BURST_W'(burst);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (exp_cost >= 0) check({tag, " direct cost"}, int'(acc_cost), exp_cost);
      if (exp_pf >= 0)   check({tag, " direct pf"}, int'(acc_pf_wait), exp_pf);
   endtask

   int cfg_list [6] = '{32'h0000, 32'h4000, 32'h0555, 32'h06AA, 32'h47FF, 32'h4123};

   initial begin
      int low;
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 reset ready", int'(ready), 1);
      check("R11 reset cost", int'(acc_cost), 0);
      check("R11 reset pf", int'(acc_pf_wait), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: defaults with timing word 0
      issue(2, 0, 0, 0, 1, 4, 2, "R5");
      issue(8, 1, 0, 0, 1, 9, 5, "R5");
      issue(12, 1, 1, 0, 0, 19, 17, "R5");
      issue(14, 1, 0, 1, 1, 10, 9, "R5");
      issue(10, 0, 0, 0, 1, 6, 4, "R5");
      // R4: mirrors and zero-wait regions
      issue(9, 1, 0, 0, 1, 9, 5, "R4");
      issue(0, 0, 0, 1, 1, 1, 0, "R4");
      issue(15, 1, 0, 0, 1, 2, 0, "R4");
      issue(2, 1, 1, 1, 1, 6, 5, "R4");
      // R7: bursts
      issue(8, 1, 0, 0, 4, 26, -1, "R7");
      issue(12, 0, 1, 1, 255, 4586, -1, "R7");
      issue(10, 1, 0, 1, 2, 1 + 9 + 1 + 9, -1, "R7");

      // R8: exact stall length
      issue(8, 0, 0, 1, 1, 5, -1, "R8");
      low = 0;
      while (!ready) begin low++; @(negedge clk); end
      check("R8 stall cycles", low, 5);
      // R8: requests during a stall are ignored
      issue(12, 1, 1, 0, 1, 19, -1, "R8");
      req_addr  = addr_of(0);
      req_write = 1'b1;
      req_valid = 1'b1;
      repeat (5) @(negedge clk);
      req_valid = 1'b0;
      check("R8 cost held while busy", int'(acc_cost), 19);
      check("R8 still stalled", int'(ready), 0);

      // R1: first-access codes
      write_cfg(32'h000C);
      issue(8, 0, 0, 0, 1, 10, -1, "R1");
      write_cfg(32'h0020);
      issue(11, 0, 0, 1, 1, 4, -1, "R1");
      write_cfg(32'h0002);
      issue(14, 0, 1, 0, 1, 4, -1, "R1");
      // R2: sequential select bits
      write_cfg(32'h0010);
      issue(9, 0, 1, 0, 1, 3, -1, "R2");
      write_cfg(32'h0000);
      issue(11, 0, 1, 1, 1, 5, -1, "R2");
      write_cfg(32'h0400);
      issue(13, 0, 1, 1, 1, 2, -1, "R2");
      // R3: derived 32-bit timings
      write_cfg(32'h0300);
      issue(13, 1, 0, 0, 1, 19, -1, "R3");
      issue(12, 1, 1, 0, 1, 19, -1, "R3");
      write_cfg(32'h0003);
      issue(14, 1, 1, 0, 1, 19, -1, "R3");
      // R10: prefetch wait
      write_cfg(32'h4000);
      issue(8, 0, 1, 0, 1, -1, 0, "R10");
      issue(14, 1, 0, 0, 1, -1, 9, "R10");
      write_cfg(32'h0000);
      issue(8, 0, 1, 0, 1, -1, 2, "R10");

      // R9: write and request at the same edge use the old word
      while (!ready) @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = 16'h000C;
      cur_req   = "R9";
      req_addr  = addr_of(8);
      req_wide  = 1'b0;
      req_seq   = 1'b0;
      req_write = 1'b0;
      req_burst = BURST_W'(1);
      req_valid = 1'b1;
      @(negedge clk);
      cfg_we    = 1'b0;
      req_valid = 1'b0;
      check("R9 old word used", int'(acc_cost), 6);
      issue(8, 0, 0, 0, 1, 10, -1, "R9");

      // R6 sweep across timing words, regions and access kinds
      foreach (cfg_list[i]) begin
         write_cfg(cfg_list[i]);
         for (int r = 0; r < 16; r++) begin
            for (int k = 0; k < 8; k++) begin
               issue(r, k[0], k[1], k[2], 1, -1, -1, "R6");
            end
         end
         for (int r = 8; r < 15; r++) begin
            issue(r, 1, 0, 0, 2 + r % 3, -1, -1, "R7");
         end
      end
      while (!ready) @(negedge clk);
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule